// File: doc/BRIEF.md
# Clock-Embedded Frame Deserializer

This block rebuilds 12-bit parallel words from a two-wire serial link made of a data line and a forwarded bit clock. The transmitter marks the end of each word by leaving the forwarded clock high across two extra bit periods instead of pulsing it low. The result is one long high phase of about three bit times. Both wires are brought into the local clock domain through a synchronizer chain and sampled with a local clock that runs at four times the bit rate.

Each rising edge of the forwarded clock, seen as a low-to-high change in the sampled copy, shifts one data bit into a capture register. When the clock has stayed high long enough to count as a frame mark, the last twelve captured bits become the output word. The two mark bits are only used to check the frame and are never output. The word-clock output falls in the same cycle as the parallel bus updates. It stays low for a fixed seven bit periods and then returns high. Runs of ordinary bits with no mark, frames that are too short, frames whose first mark bit is wrong, and clock-high runs of an odd length never produce a word.

Top module: `ckFrameDeser`

## Requirements
- R1: While reset is asserted, and right after it, `wordClk` is 1 and `wordOut` is all zeros.
- R2: A run of at least `BOUND_TICKS` (10) consecutive high samples of the synchronized forwarded clock is a frame mark. A word is issued on the tenth high sample, so the outputs change `SYNC_STAGES + BOUND_TICKS` (12) clock cycles after the rising forwarded-clock edge of the twelfth data bit arrives at the pin.
- R3: Data is sampled at each forwarded-clock rising edge. The twelve samples taken just before the mark form the word, with the first-received bit on `wordOut[0]` and the twelfth on `wordOut[11]`. The mark bits never appear on `wordOut`.
- R4: `wordOut` changes only in the cycle in which `wordClk` falls.
- R5: After it falls, `wordClk` stays low for exactly `7*OVS` (28) clock cycles and then returns to 1.
- R6: Ordinary bits received before a word's twelve bits, such as filler sent between words, do not change the issued word value.
- R7: With no frame mark, no `wordClk` pulse occurs: `wordClk` stays 1 and `wordOut` holds its value.
- R8: The first mark bit is the data sampled on high sample `OVS+1` (the 5th) of the mark run. If it equals data bit 12, the word is dropped: no pulse, and `wordOut` keeps its value.
- R9: A mark that arrives after fewer than twelve data bits since the last mark, or since reset, drops the word.
- R10: A clock-high run that ends after fewer than `OVS/2` (2) samples, or after between `OVS/2+2` (4) and `BOUND_TICKS-1` (9) samples, discards all bits collected so far for the current word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, four times the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| fwdClkIn | input | 1 | Forwarded serial bit clock with embedded frame mark |
| serDataIn | input | 1 | Serial data line |
| wordOut | output | WORD_W | Recovered parallel word |
| wordClk | output | 1 | Word clock; falls on each update, low for seven bit periods |

## Verification
The bound checker watches every cycle for these rules. The word bus may change only while the word clock goes low. Every low phase of the word clock lasts exactly 28 cycles. Every falling edge must be preceded by a mark run that reached its threshold, at least twelve collected bits, and a first mark bit that differs from the last data bit. The reset values are also checked. Other points can only be shown by the bench's scenarios, because they involve the exact bit values and the input timing. These are the bit ordering and the word value, the 12-cycle latency from the last data edge, the discarding of filler bits, and the dropping of words after a short frame, a bad mark bit, or an odd clock-high run in the middle of a word.

// File: rtl/ckFramePkg.sv
package ckFramePkg;

  // Strobes from the frame control to the capture datapath
  typedef struct packed {
    logic shiftEn;  // forwarded clock rose: take one data bit
    logic markEn;   // sample point of the first mark bit
    logic load;     // valid frame end: publish the word
  } pathCtl_t;

endpackage

// File: rtl/ckSync.sv
module ckSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[0] <= '0;
        else       stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[s] <= '0;
        else       stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/ckFrameCtl.sv
module ckFrameCtl
  import ckFramePkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int OVS         = 4,
  parameter int BOUND_TICKS = 10,
  localparam int RUN_W      = $clog2(BOUND_TICKS + 1),
  localparam int CNT_W      = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkS,
  input  logic             frameOk,
  output pathCtl_t         ctl,
  output logic [RUN_W-1:0] runLen,
  output logic [CNT_W-1:0] bitCount,
  output logic             wordClk
);

  localparam int NORM_MIN  = OVS / 2;
  localparam int NORM_MAX  = OVS / 2 + 1;
  localparam int MARK_AT   = OVS;
  localparam int LOW_TICKS = 7 * OVS;
  localparam int LOW_W     = $clog2(LOW_TICKS);

  logic             prevClk;
  logic             riseNow;
  logic             fallNow;
  logic             atBound;
  logic             badRun;
  logic             loadNow;
  logic [LOW_W-1:0] lowCnt;

  assign riseNow = clkS & ~prevClk;
  assign fallNow = ~clkS & prevClk;
  assign atBound = clkS && (runLen == RUN_W'(BOUND_TICKS - 1));
  assign badRun  = fallNow &&
                   ((runLen < RUN_W'(NORM_MIN)) ||
                    ((runLen > RUN_W'(NORM_MAX)) && (runLen < RUN_W'(BOUND_TICKS))));
  assign loadNow = atBound && (bitCount >= CNT_W'(WORD_W)) && frameOk;

  always_comb begin
    ctl.shiftEn = riseNow;
    ctl.markEn  = clkS && (runLen == RUN_W'(MARK_AT));
    ctl.load    = loadNow;
  end

  // Length of the current high run of the sampled clock, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      runLen  <= '0;
    end else begin
      prevClk <= clkS;
      if (!clkS)
        runLen <= '0;
      else if (runLen != RUN_W'(BOUND_TICKS))
        runLen <= runLen + 1'b1;
    end
  end

  // Bits collected since the last mark, saturating at the word width
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bitCount <= '0;
    else if (atBound || badRun)
      bitCount <= '0;
    else if (riseNow && (bitCount < CNT_W'(WORD_W)))
      bitCount <= bitCount + 1'b1;
  end

  // Word clock: low for a fixed number of oversample ticks after each load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordClk <= 1'b1;
      lowCnt  <= '0;
    end else if (loadNow) begin
      wordClk <= 1'b0;
      lowCnt  <= LOW_W'(LOW_TICKS - 1);
    end else if (!wordClk) begin
      if (lowCnt == '0) wordClk <= 1'b1;
      else              lowCnt  <= lowCnt - 1'b1;
    end
  end

endmodule

// File: rtl/ckFramePath.sv
module ckFramePath
  import ckFramePkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataS,
  input  pathCtl_t          ctl,
  output logic [WORD_W-1:0] wordOut,
  output logic              frameOk,
  output logic              markBit,
  output logic              lastBit
);

  logic [WORD_W-1:0] shReg;

  // Newest bit enters at the top, so the oldest of the last WORD_W sits at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shReg <= '0;
    else if (ctl.shiftEn)
      shReg <= {dataS, shReg[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      markBit <= 1'b0;
    else if (ctl.markEn)
      markBit <= dataS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      wordOut <= '0;
    else if (ctl.load)
      wordOut <= shReg;
  end

  assign lastBit = shReg[WORD_W-1];
  assign frameOk = markBit != lastBit;

endmodule

// File: rtl/ckFrameDeser.sv
module ckFrameDeser
  import ckFramePkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int OVS         = 4,
  parameter int SYNC_STAGES = 2,
  parameter int BOUND_TICKS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fwdClkIn,
  input  logic              serDataIn,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordClk
);

  localparam int RUN_W = $clog2(BOUND_TICKS + 1);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [1:0]       syncOut;
  logic             clkS;
  logic             dataS;
  logic             frameOk;
  logic             markBit;
  logic             lastBit;
  logic [RUN_W-1:0] runLen;
  logic [CNT_W-1:0] bitCount;
  pathCtl_t         ctlS;

  ckSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  ({fwdClkIn, serDataIn}),
    .dout (syncOut)
  );

  assign clkS  = syncOut[1];
  assign dataS = syncOut[0];

  ckFrameCtl #(.WORD_W(WORD_W), .OVS(OVS), .BOUND_TICKS(BOUND_TICKS)) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .clkS     (clkS),
    .frameOk  (frameOk),
    .ctl      (ctlS),
    .runLen   (runLen),
    .bitCount (bitCount),
    .wordClk  (wordClk)
  );

  ckFramePath #(.WORD_W(WORD_W)) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .dataS   (dataS),
    .ctl     (ctlS),
    .wordOut (wordOut),
    .frameOk (frameOk),
    .markBit (markBit),
    .lastBit (lastBit)
  );

endmodule

// File: rtl/ckFrameChk.sv
module ckFrameChk #(
  parameter int WORD_W      = 12,
  parameter int OVS         = 4,
  parameter int BOUND_TICKS = 10,
  localparam int RUN_W      = $clog2(BOUND_TICKS + 1),
  localparam int CNT_W      = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wordClk,
  input logic [WORD_W-1:0] wordOut,
  input logic [RUN_W-1:0]  runLen,
  input logic [CNT_W-1:0]  bitCount,
  input logic              clkS,
  input logic              markBit,
  input logic              lastBit
);

  localparam int LOW_TICKS = 7 * OVS;

  int unsigned lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lowRun <= 0;
    else if (!wordClk) lowRun <= lowRun + 1;
    else              lowRun <= 0;
  end

  // R1: reset values
  p_reset_vals_r1: assert property (@(posedge clk)
    !rstN |=> (wordClk && (wordOut == '0)));

  // R2: a pulse only follows a completed mark run on the sampled clock
  p_mark_before_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wordClk) |-> ($past(clkS) && ($past(runLen) == RUN_W'(BOUND_TICKS - 1))));

  // R4: the bus only moves in the cycle the word clock falls
  p_update_at_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordOut) |-> $fell(wordClk));

  // R5: the low phase has a fixed length
  p_low_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordClk) |-> (lowRun == LOW_TICKS));

  // R8: the first mark bit must be the inverse of data bit 12
  p_mark_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wordClk) |-> ($past(markBit) != $past(lastBit)));

  // R9: a full word must have been collected
  p_full_word_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wordClk) |-> ($past(bitCount) >= CNT_W'(WORD_W)));

endmodule

bind ckFrameDeser ckFrameChk #(
  .WORD_W      (WORD_W),
  .OVS         (OVS),
  .BOUND_TICKS (BOUND_TICKS)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .wordClk  (wordClk),
  .wordOut  (wordOut),
  .runLen   (runLen),
  .bitCount (bitCount),
  .clkS     (clkS),
  .markBit  (markBit),
  .lastBit  (lastBit)
);

// File: tb/ckFrameDeser_tb_top.sv
module ckFrameDeser_tb_top;

  localparam int WORD_W  = 12;
  localparam int OVS     = 4;
  localparam int SYNC    = 2;
  localparam int BOUND   = 10;
  localparam int LOW_LEN = 7 * OVS;
  localparam int LAT     = SYNC + BOUND;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              fwdClkIn = 1'b0;
  logic              serDataIn = 1'b0;
  logic [WORD_W-1:0] wordOut;
  logic              wordClk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int falls = 0;
  int fallCyc = 0;
  int lastRiseCyc = 0;
  bit haveFall = 0;
  bit done = 0;
  logic [WORD_W-1:0] lastWord = '0;
  logic [WORD_W-1:0] prevWord = '0;
  logic              prevWc = 1'b1;

  always #5 clk = ~clk;

  always @(posedge clk) cyc++;

  ckFrameDeser dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .fwdClkIn  (fwdClkIn),
    .serDataIn (serDataIn),
    .wordOut   (wordOut),
    .wordClk   (wordClk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Output monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      prevWc   = 1'b1;
      prevWord = '0;
      haveFall = 0;
    end else begin
      if (prevWc && !wordClk) begin
        falls++;
        lastWord = wordOut;
        fallCyc  = cyc;
        haveFall = 1;
      end
      if (wordOut != prevWord)
        check(prevWc && !wordClk, "R4 bus change without word-clock fall", wordOut, prevWord);
      if (!prevWc && wordClk && haveFall)
        check((cyc - fallCyc) == LOW_LEN, "R5 word-clock low length", cyc - fallCyc, LOW_LEN);
      prevWc   = wordClk;
      prevWord = wordOut;
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic driveBit(input logic b, input bit isLast);
    for (int i = 0; i < OVS; i++) begin
      serDataIn = b;
      fwdClkIn  = (i >= OVS / 2);
      if (isLast && i == OVS / 2) lastRiseCyc = cyc;
      @(negedge clk);
    end
  endtask

  task automatic driveMark(input logic m13, input logic m14);
    fwdClkIn  = 1'b1;
    serDataIn = m13;
    ticks(OVS);
    serDataIn = m14;
    ticks(OVS);
  endtask

  task automatic sendWord(input logic [WORD_W-1:0] w, input bit badMark);
    for (int i = 0; i < WORD_W; i++) driveBit(w[i], i == WORD_W - 1);
    driveMark(badMark ? w[WORD_W-1] : ~w[WORD_W-1], w[WORD_W-1]);
  endtask

  task automatic idle(input int n);
    fwdClkIn  = 1'b1;
    serDataIn = 1'b0;
    ticks(n);
  endtask

  task automatic expectWord(input logic [WORD_W-1:0] w, input string req);
    int f0;
    f0 = falls;
    sendWord(w, 0);
    idle(40);
    check(falls == f0 + 1, {req, " one pulse per word"}, falls - f0, 1);
    check(lastWord == w, {req, " word value"}, lastWord, w);
    check((fallCyc - lastRiseCyc) == LAT, "R2 latency from last data edge", fallCyc - lastRiseCyc, LAT);
  endtask

  task automatic testReset();
    ticks(3);
    check(wordClk == 1'b1, "R1 word clock in reset", wordClk, 1);
    check(wordOut == '0, "R1 word bus in reset", wordOut, 0);
    rstN = 1'b1;
    ticks(4);
    check(wordClk == 1'b1, "R1 word clock after reset", wordClk, 1);
  endtask

  task automatic testBasic();
    expectWord(12'hA5C, "R3");
    expectWord(12'h001, "R3 first bit to bit 0");
    expectWord(12'h800, "R3 last bit to bit 11");
  endtask

  task automatic testBackToBack();
    int f0;
    f0 = falls;
    sendWord(12'hFFF, 0);
    sendWord(12'h000, 0);
    sendWord(12'h555, 0);
    idle(40);
    check(falls == f0 + 3, "R3 back-to-back words", falls - f0, 3);
    check(lastWord == 12'h555, "R3 back-to-back last value", lastWord, 12'h555);
  endtask

  task automatic testFiller();
    int f0;
    f0 = falls;
    for (int i = 0; i < 20; i++) driveBit(i[0], 0);
    check(falls == f0, "R6 filler bits give no word", falls - f0, 0);
    check(wordClk == 1'b1, "R6 word clock high during filler", wordClk, 1);
    expectWord(12'h3C6, "R6 word after filler");
  endtask

  task automatic testNoMark();
    int f0;
    logic [WORD_W-1:0] w0;
    f0 = falls;
    w0 = wordOut;
    idle(200);
    for (int i = 0; i < 30; i++) driveBit(1'b1, 0);
    check(falls == f0, "R7 no pulse without mark", falls - f0, 0);
    check(wordClk == 1'b1, "R7 word clock stays high", wordClk, 1);
    check(wordOut == w0, "R7 bus holds", wordOut, w0);
    idle(20);
  endtask

  task automatic testBadMark();
    int f0;
    logic [WORD_W-1:0] w0;
    f0 = falls;
    w0 = wordOut;
    sendWord(12'h7B2, 1);
    idle(40);
    check(falls == f0, "R8 bad mark bit drops word", falls - f0, 0);
    check(wordOut == w0, "R8 bus unchanged", wordOut, w0);
    expectWord(12'h7B2, "R8 recovery");
  endtask

  task automatic testShort();
    int f0;
    logic [WORD_W-1:0] w0;
    f0 = falls;
    w0 = wordOut;
    for (int i = 0; i < 8; i++) driveBit(1'b1, 0);
    driveMark(1'b0, 1'b1);
    idle(40);
    check(falls == f0, "R9 short frame drops word", falls - f0, 0);
    check(wordOut == w0, "R9 bus unchanged", wordOut, w0);
  endtask

  task automatic testOddRun();
    int f0;
    logic [WORD_W-1:0] w0;
    f0 = falls;
    w0 = wordOut;
    for (int i = 0; i < 6; i++) driveBit(1'b1, 0);
    fwdClkIn  = 1'b0;
    serDataIn = 1'b1;
    ticks(OVS / 2);
    fwdClkIn = 1'b1;
    ticks(6);
    for (int i = 0; i < 6; i++) driveBit(1'b0, i == 5);
    driveMark(1'b1, 1'b0);
    idle(40);
    check(falls == f0, "R10 odd high run clears partial word", falls - f0, 0);
    check(wordOut == w0, "R10 bus unchanged", wordOut, w0);
    expectWord(12'h9E4, "R10 recovery");
  endtask

  task automatic testResetMidPulse();
    sendWord(12'h6A9, 0);
    idle(6);
    check(wordClk == 1'b0, "R5 word clock low mid-pulse", wordClk, 0);
    rstN     = 1'b0;
    fwdClkIn = 1'b0;
    ticks(2);
    check(wordClk == 1'b1, "R1 reset ends pulse", wordClk, 1);
    check(wordOut == '0, "R1 reset clears bus", wordOut, 0);
    rstN = 1'b1;
    ticks(4);
    expectWord(12'h2D7, "R1 word after reset");
  endtask

  initial begin
    ticks(1);
    testReset();
    testBasic();
    testBackToBack();
    testFiller();
    testNoMark();
    testBadMark();
    testShort();
    testOddRun();
    testResetMidPulse();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule